// File: doc/BRIEF.md
# Shared-Memory Ring FIFO Agent

This block moves bytes through ring buffers that live in another processor's memory. It reaches that memory through a single-byte memory port, and it may drive the port only while it owns the bus. Ownership comes from a request/grant pair. Several independent channels are served. For each channel the agent keeps a base address and local copies of the ring's size mask and of both ring indices. Each ring has three control bytes just below its base address:

- the mask (ring length minus one) at base minus 3;
- the producer index at base minus 2;
- the consumer index at base minus 1.

The agent is the owner of one index for each access direction. It rereads the far index from shared memory inside an ownership window.

A client issues one command at a time on a valid/ready command channel and receives one result on a valid/ready response channel. The available commands are:

- initialise a channel;
- ask whether the ring is empty;
- ask whether the ring is full;
- take a byte without waiting, which returns a valid flag;
- take a byte and wait until one is present;
- put a byte, waiting while the ring is full.

A command is accepted on the clock edge where `cmd_valid` and `cmd_ready` are both high. The response is offered with `rsp_valid` and holds steady until `rsp_ready` takes it. No new command is accepted before that.

Top module: `ring_fifo_agent`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `bus_req`, `mem_valid` and `rsp_valid` are 0. Every channel starts disabled (base 0).
- R2: Command 0 (init) stores `cmd_addr` as the channel base. If the base is nonzero, the agent uses one ownership window of three reads, at base-3, base-2 and base-1, to load the local mask, producer index and consumer index, and answers flag 1. A zero base causes no bus request and answers flag 0. A later init resynchronises the local copies from memory.
- R3: On a disabled channel, the empty query answers 1 and the full query answers 0. Both take-byte commands answer flag 0 with byte 0. A put performs no memory access. None of these raises `bus_req`.
- R4: Command 1 (empty) reads base-2 in one window and answers flag 1 exactly when that byte equals the local consumer index.
- R5: Command 2 (full) reads base-1 in one window and answers flag 1 exactly when (local producer index + 1) AND mask equals that byte.
- R6: Command 3 (non-blocking take) uses one window. If the ring is not empty, it reads the byte at base + consumer index, writes (index+1) AND mask to base-1, updates the local copy, and answers flag 1 with the byte. If the ring is empty, it answers flag 0 and writes nothing.
- R7: Command 4 (blocking take) repeats the emptiness check in fresh ownership windows until the producer index differs. It then completes as in R6.
- R8: Command 5 (put) repeats the fullness check in fresh windows while the ring is full. It then writes `cmd_byte` at base + producer index and writes (index+1) AND mask to base-2 in the same window, and answers flag 1.
- R9: A memory access (`mem_valid`) occurs only while both `bus_req` and `bus_gnt` are high. The address, direction and write data stay stable until `mem_ready`. After dropping `bus_req`, the agent waits for `bus_gnt` to fall before it requests again or responds.
- R10: A response stays valid, with stable flag and byte, until `rsp_ready`. `cmd_ready` is high only when no response is pending and no bus window is open.
- R11: Command codes 6 and 7 are answered with flag 0 and byte 0, with no bus activity.
- R12: Commands on one channel never change another channel's local indices or its control bytes in memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Agent idle and able to take a command |
| cmd_op | input | 3 | Command code (0 init, 1 empty, 2 full, 3 take, 4 blocking take, 5 put) |
| cmd_ch | input | CW | Channel number |
| cmd_addr | input | AW | Ring base address for init |
| cmd_byte | input | 8 | Byte to put |
| rsp_valid | output | 1 | Result offered |
| rsp_ready | input | 1 | Client takes the result |
| rsp_flag | output | 1 | Empty/full answer, take valid, put done, init enabled |
| rsp_byte | output | 8 | Byte taken (0 for other commands) |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership granted |
| mem_valid | output | 1 | Memory access offered |
| mem_ready | input | 1 | Memory access completes this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid in the completing cycle of a read |

## Verification
The assertions assume the arbiter never withdraws `bus_gnt` while `bus_req` is held. They also assume the memory answers a read in the cycle it raises `mem_ready`. The bench arbiter grants and releases only after a random delay that follows the request edge, and never revokes a live grant. Its memory model returns read data combinationally from the presented address and drives `mem_ready` randomly, so wait states occur often. The other processor's writes to the control bytes are made only while the agent is blocked and polling. Afterwards the channel is re-initialised, so the agent's local copies are never out of step with memory.

// File: rtl/ring_agent_pkg.sv
package ring_agent_pkg;
  localparam int IDX_W = 8;

  typedef enum logic [2:0] {
    OP_INIT    = 3'd0,
    OP_EMPTY   = 3'd1,
    OP_FULL    = 3'd2,
    OP_GET_NB  = 3'd3,
    OP_GET_BLK = 3'd4,
    OP_PUT     = 3'd5
  } ring_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ACQ,
    S_ACC,
    S_REL,
    S_RSP
  } seq_state_e;
endpackage

// File: rtl/ring_chan_table.sv
module ring_chan_table #(
  parameter int NCH = 2,
  parameter int AW  = 16,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int IW = ring_agent_pkg::IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] rd_ch,
  output logic [AW-1:0] rd_base,
  output logic [IW-1:0] rd_mask,
  output logic [IW-1:0] rd_in,
  output logic [IW-1:0] rd_out,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_ch,
  input  logic [AW-1:0] wr_base,
  input  logic [IW-1:0] wr_mask,
  input  logic [IW-1:0] wr_in,
  input  logic [IW-1:0] wr_out
);
  logic [AW-1:0] base_r [NCH];
  logic [IW-1:0] mask_r [NCH];
  logic [IW-1:0] in_r   [NCH];
  logic [IW-1:0] out_r  [NCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        base_r[i] <= '0;
        mask_r[i] <= '0;
        in_r[i]   <= '0;
        out_r[i]  <= '0;
      end
    end else if (wr_en) begin
      for (int i = 0; i < NCH; i++) begin
        if (wr_ch == CW'(i)) begin
          base_r[i] <= wr_base;
          mask_r[i] <= wr_mask;
          in_r[i]   <= wr_in;
          out_r[i]  <= wr_out;
        end
      end
    end
  end

  // An out-of-range channel reads as disabled.
  always_comb begin
    rd_base = '0;
    rd_mask = '0;
    rd_in   = '0;
    rd_out  = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_ch == CW'(i)) begin
        rd_base = base_r[i];
        rd_mask = mask_r[i];
        rd_in   = in_r[i];
        rd_out  = out_r[i];
      end
    end
  end
endmodule

// File: rtl/ring_addr_gen.sv
module ring_addr_gen #(
  parameter int AW = 16,
  localparam int IW = ring_agent_pkg::IDX_W
) (
  input  logic [2:0]    op,
  input  logic [1:0]    step,
  input  logic [AW-1:0] base,
  input  logic [IW-1:0] mask,
  input  logic [IW-1:0] in_idx,
  input  logic [IW-1:0] out_idx,
  input  logic [7:0]    put_byte,
  output logic [AW-1:0] addr,
  output logic          we,
  output logic [7:0]    wdata,
  output logic [IW-1:0] nxt_in,
  output logic [IW-1:0] nxt_out
);
  import ring_agent_pkg::*;

  localparam logic [AW-1:0] OFS_MASK = AW'(3);
  localparam logic [AW-1:0] OFS_IN   = AW'(2);
  localparam logic [AW-1:0] OFS_OUT  = AW'(1);

  assign nxt_in  = (in_idx + 1'b1) & mask;
  assign nxt_out = (out_idx + 1'b1) & mask;

  always_comb begin
    addr  = base - OFS_IN;
    we    = 1'b0;
    wdata = '0;
    case (op)
      OP_INIT: begin
        case (step)
          2'd0:    addr = base - OFS_MASK;
          2'd1:    addr = base - OFS_IN;
          default: addr = base - OFS_OUT;
        endcase
      end
      OP_EMPTY: addr = base - OFS_IN;
      OP_FULL:  addr = base - OFS_OUT;
      OP_GET_NB, OP_GET_BLK: begin
        case (step)
          2'd0: addr = base - OFS_IN;
          2'd1: addr = base + AW'(out_idx);
          default: begin
            addr  = base - OFS_OUT;
            we    = 1'b1;
            wdata = nxt_out;
          end
        endcase
      end
      OP_PUT: begin
        case (step)
          2'd0: addr = base - OFS_OUT;
          2'd1: begin
            addr  = base + AW'(in_idx);
            we    = 1'b1;
            wdata = put_byte;
          end
          default: begin
            addr  = base - OFS_IN;
            we    = 1'b1;
            wdata = nxt_in;
          end
        endcase
      end
      default: addr = base - OFS_IN;
    endcase
  end
endmodule

// File: rtl/ring_bus_seq.sv
module ring_bus_seq #(
  parameter int NCH = 2,
  parameter int AW  = 16,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int IW = ring_agent_pkg::IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [CW-1:0] cmd_ch,
  input  logic [AW-1:0] cmd_addr,
  input  logic [7:0]    cmd_byte,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_flag,
  output logic [7:0]    rsp_byte,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          mem_valid,
  input  logic          mem_ready,
  input  logic [7:0]    mem_rdata,
  input  logic [AW-1:0] tbl_base,
  input  logic [IW-1:0] tbl_mask,
  input  logic [IW-1:0] tbl_in,
  input  logic [IW-1:0] tbl_out,
  output logic          tbl_wr,
  output logic [CW-1:0] tbl_ch,
  output logic [2:0]    cur_op,
  output logic [1:0]    cur_step,
  output logic [AW-1:0] cur_base,
  output logic [IW-1:0] cur_mask,
  output logic [IW-1:0] cur_in,
  output logic [IW-1:0] cur_out,
  output logic [7:0]    cur_byte,
  input  logic [IW-1:0] nxt_in,
  input  logic [IW-1:0] nxt_out
);
  import ring_agent_pkg::*;

  seq_state_e    state_q;
  logic [2:0]    op_q;
  logic [CW-1:0] ch_q;
  logic [1:0]    step_q;
  logic          retry_q;
  logic          flag_q;
  logic [7:0]    byte_q;
  logic [AW-1:0] base_q;
  logic [IW-1:0] mask_q, in_q, out_q;
  logic          is_get, op_known;

  assign is_get   = (op_q == OP_GET_NB) || (op_q == OP_GET_BLK);
  assign op_known = (cmd_op <= OP_PUT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      op_q    <= '0;
      ch_q    <= '0;
      step_q  <= '0;
      retry_q <= 1'b0;
      flag_q  <= 1'b0;
      byte_q  <= '0;
      base_q  <= '0;
      mask_q  <= '0;
      in_q    <= '0;
      out_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (cmd_valid) begin
          op_q    <= cmd_op;
          ch_q    <= cmd_ch;
          step_q  <= '0;
          retry_q <= 1'b0;
          flag_q  <= 1'b0;
          byte_q  <= (cmd_op == OP_PUT) ? cmd_byte : 8'h00;
          base_q  <= tbl_base;
          mask_q  <= tbl_mask;
          in_q    <= tbl_in;
          out_q   <= tbl_out;
          if (cmd_op == OP_INIT) begin
            base_q  <= cmd_addr;
            mask_q  <= '0;
            in_q    <= '0;
            out_q   <= '0;
            state_q <= (cmd_addr != '0) ? S_ACQ : S_RSP;
          end else if (op_known && tbl_base != '0) begin
            state_q <= S_ACQ;
          end else begin
            flag_q  <= op_known && (cmd_op == OP_EMPTY);
            state_q <= S_RSP;
          end
        end
        S_ACQ: if (bus_gnt) state_q <= S_ACC;
        S_ACC: if (mem_ready) begin
          step_q <= step_q + 2'd1;
          case (op_q)
            OP_INIT: begin
              case (step_q)
                2'd0: mask_q <= mem_rdata;
                2'd1: in_q   <= mem_rdata;
                default: begin
                  out_q   <= mem_rdata;
                  flag_q  <= 1'b1;
                  state_q <= S_REL;
                end
              endcase
            end
            OP_EMPTY: begin
              flag_q  <= (mem_rdata == out_q);
              state_q <= S_REL;
            end
            OP_FULL: begin
              flag_q  <= (mem_rdata == nxt_in);
              state_q <= S_REL;
            end
            OP_GET_NB, OP_GET_BLK: begin
              case (step_q)
                2'd0: if (mem_rdata == out_q) begin
                  retry_q <= (op_q == OP_GET_BLK);
                  state_q <= S_REL;
                end
                2'd1: byte_q <= mem_rdata;
                default: begin
                  out_q   <= nxt_out;
                  flag_q  <= 1'b1;
                  state_q <= S_REL;
                end
              endcase
            end
            default: begin
              case (step_q)
                2'd0: if (mem_rdata == nxt_in) begin
                  retry_q <= 1'b1;
                  state_q <= S_REL;
                end
                2'd1: ;
                default: begin
                  in_q    <= nxt_in;
                  flag_q  <= 1'b1;
                  state_q <= S_REL;
                end
              endcase
            end
          endcase
        end
        S_REL: if (!bus_gnt) begin
          if (retry_q) begin
            retry_q <= 1'b0;
            step_q  <= '0;
            state_q <= S_ACQ;
          end else begin
            state_q <= S_RSP;
          end
        end
        default: if (rsp_ready) state_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state_q == S_IDLE);
  assign bus_req   = (state_q == S_ACQ) || (state_q == S_ACC);
  assign mem_valid = (state_q == S_ACC);
  assign rsp_valid = (state_q == S_RSP);
  assign rsp_flag  = flag_q;
  assign rsp_byte  = is_get ? byte_q : 8'h00;
  assign tbl_wr    = (state_q == S_RSP) && rsp_ready && (op_q <= OP_PUT);
  assign tbl_ch    = ch_q;
  assign cur_op    = op_q;
  assign cur_step  = step_q;
  assign cur_base  = base_q;
  assign cur_mask  = mask_q;
  assign cur_in    = in_q;
  assign cur_out   = out_q;
  assign cur_byte  = byte_q;

  // R9: memory is touched only inside an ownership window
  assert_mem_owned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (bus_req && bus_gnt));

  // R10: a pending response holds its content
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_flag) && $stable(rsp_byte)));

  // R10: one command at a time
  assert_single_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!rsp_valid && !bus_req && !mem_valid));
endmodule

// File: rtl/ring_fifo_agent.sv
module ring_fifo_agent #(
  parameter int NCH = 2,
  parameter int AW  = 16,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [CW-1:0] cmd_ch,
  input  logic [AW-1:0] cmd_addr,
  input  logic [7:0]    cmd_byte,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_flag,
  output logic [7:0]    rsp_byte,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata
);
  localparam int IW = ring_agent_pkg::IDX_W;

  logic [AW-1:0] tbl_base, cur_base;
  logic [IW-1:0] tbl_mask, tbl_in, tbl_out;
  logic [IW-1:0] cur_mask, cur_in, cur_out, nxt_in, nxt_out;
  logic          tbl_wr;
  logic [CW-1:0] tbl_ch;
  logic [2:0]    cur_op;
  logic [1:0]    cur_step;
  logic [7:0]    cur_byte;

  ring_chan_table #(.NCH(NCH), .AW(AW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_ch(cmd_ch), .rd_base(tbl_base), .rd_mask(tbl_mask),
    .rd_in(tbl_in), .rd_out(tbl_out),
    .wr_en(tbl_wr), .wr_ch(tbl_ch), .wr_base(cur_base),
    .wr_mask(cur_mask), .wr_in(cur_in), .wr_out(cur_out)
  );

  ring_bus_seq #(.NCH(NCH), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_ch(cmd_ch), .cmd_addr(cmd_addr), .cmd_byte(cmd_byte),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_flag(rsp_flag), .rsp_byte(rsp_byte),
    .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .tbl_base(tbl_base), .tbl_mask(tbl_mask), .tbl_in(tbl_in), .tbl_out(tbl_out),
    .tbl_wr(tbl_wr), .tbl_ch(tbl_ch),
    .cur_op(cur_op), .cur_step(cur_step), .cur_base(cur_base),
    .cur_mask(cur_mask), .cur_in(cur_in), .cur_out(cur_out), .cur_byte(cur_byte),
    .nxt_in(nxt_in), .nxt_out(nxt_out)
  );

  ring_addr_gen #(.AW(AW)) u_addr (
    .op(cur_op), .step(cur_step), .base(cur_base), .mask(cur_mask),
    .in_idx(cur_in), .out_idx(cur_out), .put_byte(cur_byte),
    .addr(mem_addr), .we(mem_we), .wdata(mem_wdata),
    .nxt_in(nxt_in), .nxt_out(nxt_out)
  );

  // R9: a stalled access keeps its address, direction and data
  assert_mem_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

  // R1: the block leaves reset idle with no request
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (cmd_ready && !bus_req && !rsp_valid));
endmodule

// File: tb/sim_ring_fifo_agent.sv
`timescale 1ns/1ps
module sim_ring_fifo_agent;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [0:0] cmd_ch = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0] cmd_byte = '0;
  logic rsp_valid, rsp_ready = 1'b0, rsp_flag;
  logic [7:0] rsp_byte;
  logic bus_req, bus_gnt = 1'b0;
  logic mem_valid, mem_ready = 1'b0, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  logic [7:0] mem [1024];
  logic cpu_we = 1'b0;
  logic [9:0] cpu_a = '0;
  logic [7:0] cpu_d = '0;
  int n_chk = 0, n_bad = 0;
  int win_cnt = 0, acc_cnt = 0, bad_acc = 0;
  logic req_prev = 1'b0;
  int gdly = 0;
  bit r_flag;
  logic [7:0] r_byte;

  int m_base [2];
  logic [7:0] m_mask [2], m_in [2], m_out [2];
  logic [7:0] exp_buf [2][16];

  always #2.5 clk = ~clk;

  ring_fifo_agent #(.NCH(2), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_ch(cmd_ch),
    .cmd_addr(cmd_addr), .cmd_byte(cmd_byte),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_flag(rsp_flag), .rsp_byte(rsp_byte),
    .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[9:0]];

  // memory, other-processor writes and bus monitors
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= 8'h00;
      req_prev <= 1'b0;
    end else begin
      if (mem_valid && mem_ready) begin
        acc_cnt <= acc_cnt + 1;
        if (!(bus_req && bus_gnt)) bad_acc <= bad_acc + 1;
        if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      end
      if (cpu_we) mem[cpu_a] <= cpu_d;
      if (bus_req && !req_prev) win_cnt <= win_cnt + 1;
      req_prev <= bus_req;
    end
  end

  // arbiter: delayed grant and release, never revokes a held request
  always @(negedge clk) begin
    mem_ready <= ($urandom % 4) != 0;
    if (!rst_n) begin
      bus_gnt <= 1'b0;
      gdly <= 0;
    end else if (bus_req != bus_gnt) begin
      if (gdly == 0) bus_gnt <= bus_req;
      else gdly <= gdly - 1;
    end else begin
      gdly <= $urandom % 4;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cpu_write(input int a, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_a = a[9:0]; cpu_d = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic do_cmd(input logic [2:0] op, input int ch, input int addr, input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_ch = 1'(ch); cmd_addr = AW'(addr); cmd_byte = b;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    do begin
      @(negedge clk);
      rsp_ready = ($urandom % 3) != 0;
    end while (!(rsp_valid && rsp_ready));
    r_flag = rsp_flag;
    r_byte = rsp_byte;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  function automatic bit mdl_empty(input int ch);
    return m_in[ch] == m_out[ch];
  endfunction

  function automatic bit mdl_full(input int ch);
    return ((m_in[ch] + 8'd1) & m_mask[ch]) == m_out[ch];
  endfunction

  task automatic init_ch(input int ch, input int base);
    int w0, a0;
    w0 = win_cnt; a0 = acc_cnt;
    do_cmd(3'd0, ch, base, 8'h00);
    m_base[ch] = base;
    m_mask[ch] = mem[base-3]; m_in[ch] = mem[base-2]; m_out[ch] = mem[base-1];
    chk("R2", "init flag", r_flag, 1);
    chk("R2", "init windows", win_cnt - w0, 1);
    chk("R2", "init reads", acc_cnt - a0, 3);
  endtask

  task automatic check_other(input int ch);
    int o;
    o = 1 - ch;
    if (m_base[o] != 0) begin
      chk("R12", "other producer byte", mem[m_base[o]-2], m_in[o]);
      chk("R12", "other consumer byte", mem[m_base[o]-1], m_out[o]);
    end
  endtask

  task automatic put_op(input int ch, input logic [7:0] b);
    int w0, b0;
    b0 = m_base[ch];
    w0 = win_cnt;
    do_cmd(3'd5, ch, 0, b);
    chk("R8", "put flag", r_flag, 1);
    chk("R8", "put data in ring", mem[b0 + m_in[ch]], b);
    exp_buf[ch][m_in[ch][3:0]] = b;
    m_in[ch] = (m_in[ch] + 8'd1) & m_mask[ch];
    chk("R8", "producer index written", mem[b0-2], m_in[ch]);
    chk("R8", "put windows", win_cnt - w0, 1);
  endtask

  task automatic getnb_op(input int ch);
    int w0;
    bit e;
    e = mdl_empty(ch);
    w0 = win_cnt;
    do_cmd(3'd3, ch, 0, 8'h00);
    chk("R6", "take valid", r_flag, !e);
    chk("R6", "take windows", win_cnt - w0, 1);
    if (!e) begin
      chk("R6", "take byte", r_byte, exp_buf[ch][m_out[ch][3:0]]);
      m_out[ch] = (m_out[ch] + 8'd1) & m_mask[ch];
    end else begin
      chk("R6", "empty take byte", r_byte, 0);
    end
    chk("R6", "consumer index in memory", mem[m_base[ch]-1], m_out[ch]);
  endtask

  initial begin : main
    int seed_dummy, w0, a0;
    seed_dummy = $urandom(32'h5EED_0042);
    m_base[0] = 0; m_base[1] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "cmd_ready after reset", cmd_ready, 1);
    chk("R1", "bus_req after reset", bus_req, 0);
    chk("R1", "mem_valid after reset", mem_valid, 0);
    chk("R1", "rsp_valid after reset", rsp_valid, 0);

    // disabled channel
    w0 = win_cnt; a0 = acc_cnt;
    do_cmd(3'd1, 0, 0, 8'h00); chk("R3", "disabled empty", r_flag, 1);
    do_cmd(3'd2, 0, 0, 8'h00); chk("R3", "disabled full", r_flag, 0);
    do_cmd(3'd3, 0, 0, 8'h00); chk("R3", "disabled take", r_flag, 0);
    do_cmd(3'd4, 0, 0, 8'h00); chk("R3", "disabled blocking take", r_flag, 0);
    chk("R3", "disabled take byte", r_byte, 0);
    do_cmd(3'd5, 0, 0, 8'h77); chk("R3", "disabled put flag", r_flag, 0);
    chk("R3", "disabled: no windows", win_cnt - w0, 0);
    chk("R3", "disabled: no accesses", acc_cnt - a0, 0);

    // ring control bytes, then init
    cpu_write(16'h0FD, 8'h07); cpu_write(16'h0FE, 8'h02); cpu_write(16'h0FF, 8'h02);
    cpu_write(16'h1FD, 8'h0F); cpu_write(16'h1FE, 8'h00); cpu_write(16'h1FF, 8'h00);
    init_ch(0, 16'h100);
    init_ch(1, 16'h200);
    do_cmd(3'd1, 0, 0, 8'h00); chk("R4", "empty after init", r_flag, 1);
    do_cmd(3'd2, 1, 0, 8'h00); chk("R5", "not full after init", r_flag, 0);

    // unknown command codes
    w0 = win_cnt;
    do_cmd(3'd6, 0, 0, 8'h55); chk("R11", "code 6 flag", r_flag, 0);
    do_cmd(3'd7, 1, 0, 8'h55); chk("R11", "code 7 flag", r_flag, 0);
    chk("R11", "code 7 byte", r_byte, 0);
    chk("R11", "no windows", win_cnt - w0, 0);

    // random mix
    for (int k = 0; k < 160; k++) begin
      int ch, sel;
      ch = $urandom % 2;
      sel = $urandom % 4;
      if (sel == 3 && mdl_full(ch)) sel = 1;
      case (sel)
        0: begin do_cmd(3'd1, ch, 0, 8'h00); chk("R4", "empty query", r_flag, mdl_empty(ch)); end
        1: begin do_cmd(3'd2, ch, 0, 8'h00); chk("R5", "full query", r_flag, mdl_full(ch)); end
        2: getnb_op(ch);
        default: put_op(ch, 8'($urandom));
      endcase
      check_other(ch);
    end

    // blocking take on ch1: drain, then another processor produces later
    for (int k = 0; k < 20; k++) if (!mdl_empty(1)) getnb_op(1);
    w0 = win_cnt;
    fork
      do_cmd(3'd4, 1, 0, 8'h00);
      begin
        repeat (60) @(negedge clk);
        cpu_write(m_base[1] + m_out[1], 8'hA5);
        cpu_write(m_base[1] - 2, (m_in[1] + 8'd1) & m_mask[1]);
      end
    join
    chk("R7", "blocking take flag", r_flag, 1);
    chk("R7", "blocking take byte", r_byte, 8'hA5);
    chk("R7", "blocking take polled", (win_cnt - w0) >= 2, 1);
    chk("R7", "consumer index written", mem[m_base[1]-1], (m_out[1] + 8'd1) & m_mask[1]);
    init_ch(1, 16'h200);

    // blocking put on ch0: fill, then another processor consumes later
    for (int k = 0; k < 10; k++) if (!mdl_full(0)) put_op(0, 8'(8'h30 + k));
    do_cmd(3'd2, 0, 0, 8'h00); chk("R5", "full after fill", r_flag, 1);
    w0 = win_cnt;
    fork
      do_cmd(3'd5, 0, 0, 8'h3C);
      begin
        repeat (60) @(negedge clk);
        cpu_write(m_base[0] - 1, (m_out[0] + 8'd1) & m_mask[0]);
      end
    join
    chk("R8", "blocking put flag", r_flag, 1);
    chk("R8", "blocking put polled", (win_cnt - w0) >= 2, 1);
    chk("R8", "blocking put data", mem[m_base[0] + m_in[0]], 8'h3C);
    chk("R8", "blocking put index", mem[m_base[0]-2], (m_in[0] + 8'd1) & m_mask[0]);
    init_ch(0, 16'h100);
    do_cmd(3'd2, 0, 0, 8'h00); chk("R2", "full after resync", r_flag, 1);
    do_cmd(3'd1, 0, 0, 8'h00); chk("R2", "not empty after resync", r_flag, 0);

    // disable by zero base
    w0 = win_cnt;
    do_cmd(3'd0, 1, 0, 8'h00); chk("R2", "zero-base init flag", r_flag, 0);
    do_cmd(3'd1, 1, 0, 8'h00); chk("R3", "re-disabled empty", r_flag, 1);
    chk("R2", "zero-base init no window", win_cnt - w0, 0);

    chk("R9", "accesses outside ownership", bad_acc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule